// File: doc/BRIEF.md
# Paired-Page Nested Redundancy Encoder

This block computes check bits for two data pages that occupy the same group of two-bit storage cells. One page holds the upper bit of every cell and the other holds the lower bit. Both pages stream in together, one bit of each per beat, with the highest-degree bit first. While they stream, the block runs two bit-serial polynomial dividers. The short divider uses a small generator and sees only the upper-bit page. The long divider uses a larger generator and sees the XOR of the two pages. The larger generator has the small one as a factor.

Because the generators are nested, the lower-bit page's short check word never needs its own divider or its own storage. The block reduces the long remainder modulo the small generator. It then removes the extra power of x that the long code applied. It XORs this result with the short remainder and outputs the lower-bit page's short check word. A controller walks the states IDLE, RUN and DONE. The transitions are: IDLE or DONE to RUN on start, RUN to RUN on start (restart), and RUN to DONE on a valid beat flagged last.

Top module: `paired_page_encoder`

## Requirements
- R1: After reset, done is 0 and all three remainder outputs are 0.
- R2: A start pulse clears all remainders and drops done in the next cycle. A beat presented in the same cycle as start is discarded.
- R3: In DONE, msb_rem equals the upper-bit page times x^SHORT_DEG modulo the short generator. The first bit streamed is the page's highest-degree coefficient.
- R4: In DONE, xor_rem equals the bitwise XOR of the two pages times x^LONG_DEG modulo the long generator.
- R5: In DONE, lsb_rem equals the lower-bit page times x^SHORT_DEG modulo the short generator. This holds when the short generator divides the long one and has constant term 1.
- R6: done rises in the cycle after the valid beat flagged last. It stays high, with all remainders unchanged, until the next start.
- R7: Beats with valid high are ignored in IDLE and in DONE, and leave every output unchanged.
- R8: Cycles with valid low inside a page are skipped, so idle gaps do not alter the result.
- R9: A one-bit page is accepted, and a page of all zeros yields zero remainders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the remainders and begins a page pair |
| valid | input | 1 | Marks a beat carrying one bit of each page |
| msb_bit | input | 1 | Upper-bit page data, highest degree first |
| lsb_bit | input | 1 | Lower-bit page data, highest degree first |
| last | input | 1 | Marks the final beat of the pages |
| done | output | 1 | Remainders are final |
| msb_rem | output | SHORT_DEG | Short remainder of the upper-bit page |
| xor_rem | output | LONG_DEG | Long remainder of the XOR of both pages |
| lsb_rem | output | SHORT_DEG | Derived short remainder of the lower-bit page |

## Verification
The bench builds the block with its default parameters. The short generator is x^8+x^4+x^3+x^2+1. The long generator is its product with x^8+x^4+x^3+x+1, which gives degree 16. These small degrees keep each division in the bench to one 64-bit word. Pages from 1 to 32 bits then exercise every fold step, including the eight inverse shifts that recover the lower-bit page's check word. Each page pair is checked against an independent long division of that page alone.

// File: rtl/nested_enc_pkg.sv
package nested_enc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } enc_state_t;
endpackage

// File: rtl/serial_rem.sv
// Bit-serial divider: remainder of (message * x^DEG) mod generator.
// TAPS is the generator without its leading x^DEG term.
module serial_rem #(
    parameter int             DEG  = 8,
    parameter logic [DEG-1:0] TAPS = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           din,
    output logic [DEG-1:0] rem
);
    logic fb;
    assign fb = din ^ rem[DEG-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (clr) begin
            rem <= '0;
        end else if (en) begin
            rem <= {rem[DEG-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end
    end
endmodule

// File: rtl/rem_fold.sv
// Reduces the long remainder modulo the short generator, then multiplies
// by x^-(LD-SD) modulo the short generator (needs constant term 1).
module rem_fold #(
    parameter int            SD         = 8,
    parameter int            LD         = 16,
    parameter logic [SD-1:0] SHORT_TAPS = '1
) (
    input  logic [LD-1:0] long_rem,
    output logic [SD-1:0] folded
);
    localparam int SHIFT = LD - SD;

    logic [LD-1:0] wide;
    logic [SD-1:0] v;
    logic [SD:0]   t;

    always_comb begin
        wide = long_rem;
        for (int i = LD - 1; i >= SD; i--) begin
            if (wide[i]) begin
                wide[i -: SD + 1] = wide[i -: SD + 1] ^ {1'b1, SHORT_TAPS};
            end
        end
        v = wide[SD-1:0];
        t = '0;
        for (int k = 0; k < SHIFT; k++) begin
            t = {1'b0, v} ^ (v[0] ? {1'b1, SHORT_TAPS} : '0);
            v = t[SD:1];
        end
        folded = v;
    end
endmodule

// File: rtl/pair_ctl.sv
module pair_ctl
    import nested_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    input  logic last,
    output logic clr,
    output logic shift_en,
    output logic done
);
    enc_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_RUN;
            ST_RUN: begin
                if (start)               state_nxt = ST_RUN;
                else if (valid && last)  state_nxt = ST_DONE;
            end
            ST_DONE: if (start) state_nxt = ST_RUN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        clr      = start;
        shift_en = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  shift_en = valid && !start;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/paired_page_encoder.sv
module paired_page_encoder #(
    parameter int                   SHORT_DEG  = 8,
    parameter logic [SHORT_DEG-1:0] SHORT_TAPS = 8'h1D,
    parameter int                   LONG_DEG   = 16,
    parameter logic [LONG_DEG-1:0]  LONG_TAPS  = 16'h071F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 valid,
    input  logic                 msb_bit,
    input  logic                 lsb_bit,
    input  logic                 last,
    output logic                 done,
    output logic [SHORT_DEG-1:0] msb_rem,
    output logic [LONG_DEG-1:0]  xor_rem,
    output logic [SHORT_DEG-1:0] lsb_rem
);
    localparam int NUM_DIV = 2;

    logic                 clr, shift_en;
    logic [NUM_DIV-1:0]   div_in;
    logic [SHORT_DEG-1:0] folded;

    assign div_in = {msb_bit ^ lsb_bit, msb_bit};

    pair_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .last(last),
        .clr(clr), .shift_en(shift_en), .done(done)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        if (g == 0) begin : g_short
            serial_rem #(.DEG(SHORT_DEG), .TAPS(SHORT_TAPS)) u_rem (
                .clk(clk), .rst_n(rst_n), .clr(clr), .en(shift_en),
                .din(div_in[g]), .rem(msb_rem)
            );
        end else begin : g_long
            serial_rem #(.DEG(LONG_DEG), .TAPS(LONG_TAPS)) u_rem (
                .clk(clk), .rst_n(rst_n), .clr(clr), .en(shift_en),
                .din(div_in[g]), .rem(xor_rem)
            );
        end
    end

    rem_fold #(.SD(SHORT_DEG), .LD(LONG_DEG), .SHORT_TAPS(SHORT_TAPS)) u_fold (
        .long_rem(xor_rem), .folded(folded)
    );

    assign lsb_rem = msb_rem ^ folded;
endmodule

// File: rtl/paired_page_encoder_chk.sv
module paired_page_encoder_chk #(
    parameter int SD = 8,
    parameter int LD = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          valid,
    input logic          last,
    input logic          done,
    input logic [SD-1:0] msb_rem,
    input logic [LD-1:0] xor_rem,
    input logic [SD-1:0] lsb_rem
);
    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && msb_rem == '0 && xor_rem == '0 && lsb_rem == '0));

    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(valid && last));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(msb_rem) && $stable(xor_rem)
                              && $stable(lsb_rem)));

    // R8
    gap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !start) |=> ($stable(msb_rem) && $stable(xor_rem)));
endmodule

bind paired_page_encoder paired_page_encoder_chk #(.SD(SHORT_DEG), .LD(LONG_DEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .last(last),
    .done(done), .msb_rem(msb_rem), .xor_rem(xor_rem), .lsb_rem(lsb_rem)
);

// File: tb/paired_page_encoder_test.sv
module paired_page_encoder_test;
    localparam logic [16:0] G_SHORT = 17'h0011D;
    localparam logic [16:0] G_LONG  = 17'h1071F;
    localparam int NV = 7;
    localparam int          LEN_T [NV] = '{1, 8, 12, 16, 24, 32, 32};
    localparam logic [31:0] MSB_T [NV] = '{32'h1, 32'hA5, 32'h000, 32'h3C91,
                                           32'hD00B1E, 32'hFFFFFFFF, 32'h8BADF00D};
    localparam logic [31:0] LSB_T [NV] = '{32'h0, 32'h5E, 32'h000, 32'hE7A2,
                                           32'h1F2E3D, 32'h12345678, 32'hC0FFEE11};

    logic clk = 0, rst_n = 0;
    logic start = 0, valid = 0, msb_bit = 0, lsb_bit = 0, last = 0;
    logic done;
    logic [7:0]  msb_rem, lsb_rem;
    logic [15:0] xor_rem;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    paired_page_encoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
        .msb_bit(msb_bit), .lsb_bit(lsb_bit), .last(last), .done(done),
        .msb_rem(msb_rem), .xor_rem(xor_rem), .lsb_rem(lsb_rem)
    );

    function automatic logic [15:0] mod_rem(input logic [31:0] page, input int len,
                                             input logic [16:0] gen, input int deg);
        logic [63:0] v;
        v = (64'(page) & ((64'd1 << len) - 64'd1)) << deg;
        for (int i = 63; i >= deg; i--)
            if (v[i]) v = v ^ (64'(gen) << (i - deg));
        return v[15:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_pulse(input bit with_beat);
        @(negedge clk);
        start = 1; valid = with_beat; msb_bit = with_beat; lsb_bit = with_beat; last = with_beat;
        @(negedge clk);
        start = 0; valid = 0; last = 0;
    endtask

    task automatic stream(input logic [31:0] m, input logic [31:0] l, input int len, input bit gaps);
        for (int b = len - 1; b >= 0; b--) begin
            if (gaps && (b % 3 == 1)) begin
                valid = 0; msb_bit = ~msb_bit;
                @(negedge clk);
            end
            if (b == 0) chk("R6 done low before last", 32'(done), 32'd0);
            valid = 1; msb_bit = m[b]; lsb_bit = l[b]; last = (b == 0);
            @(negedge clk);
        end
        valid = 0; last = 0;
        chk("R6 done after last", 32'(done), 32'd1);
    endtask

    task automatic check_results(input logic [31:0] m, input logic [31:0] l, input int len);
        chk("R3 msb_rem", 32'(msb_rem), 32'(mod_rem(m, len, G_SHORT, 8)));
        chk("R4 xor_rem", 32'(xor_rem), 32'(mod_rem(m ^ l, len, G_LONG, 16)));
        chk("R5 lsb_rem", 32'(lsb_rem), 32'(mod_rem(l, len, G_SHORT, 8)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] keep_x;
        logic [7:0]  keep_m, keep_l;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", 32'(done), 0);
        chk("R1 rems", {msb_rem, xor_rem, lsb_rem}, 0);
        rst_n = 1;
        @(negedge clk);
        // R7: beats in IDLE ignored
        valid = 1; msb_bit = 1; lsb_bit = 0; last = 1;
        repeat (3) @(negedge clk);
        valid = 0; last = 0;
        chk("R7 idle rems", {msb_rem, xor_rem, lsb_rem}, 0);
        chk("R7 idle done", 32'(done), 0);

        // table walk, R3 R4 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            start_pulse(0);
            chk("R2 cleared", {31'd0, done}, 0);
            stream(MSB_T[i], LSB_T[i], LEN_T[i], (i % 2) == 1);
            check_results(MSB_T[i], LSB_T[i], LEN_T[i]);
            if (LEN_T[i] == 12) chk("R9 zero page", {msb_rem, xor_rem, lsb_rem}, 0);
        end

        // R6/R7: hold in DONE despite further beats
        keep_m = msb_rem; keep_x = xor_rem; keep_l = lsb_rem;
        valid = 1; msb_bit = 1; lsb_bit = 1; last = 1;
        repeat (4) @(negedge clk);
        valid = 0; last = 0;
        chk("R7 done hold", {msb_rem, xor_rem, lsb_rem}, {keep_m, keep_x, keep_l});
        chk("R6 done stays", 32'(done), 1);

        // R2: beat together with start is discarded
        start_pulse(1);
        chk("R2 start beat ignored done", 32'(done), 0);
        chk("R2 start beat ignored rems", {msb_rem, xor_rem, lsb_rem}, 0);
        stream(32'h6D, 32'h93, 8, 0);
        check_results(32'h6D, 32'h93, 8);

        // R2: restart mid-page discards partial state
        start_pulse(0);
        valid = 1; msb_bit = 1; lsb_bit = 0; last = 0;
        repeat (5) @(negedge clk);
        valid = 0;
        start_pulse(0);
        chk("R2 restart clears", {msb_rem, xor_rem, lsb_rem}, 0);
        stream(32'h1, 32'h1, 1, 0);
        check_results(32'h1, 32'h1, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule